// File: doc/BRIEF.md
# Flash Program/Erase Controller

This block sits on the host side of an 8-bit parallel NOR flash bus and turns one request into a complete program or erase transaction. A request names an operation (byte program, sector erase or chip erase), a target address and, for programming, a data byte. The controller writes the command sequence the flash expects, with both unlock writes in front of each command byte. It then reads the flash status until it can declare the operation finished or failed.

Completion is detected in one of two ways, chosen per request by `toggle_mode_i`. In data-polling mode the controller compares bit 7 of a status read with bit 7 of the expected final data. In toggle mode it watches whether bit 6 changes between consecutive reads. In both modes bit 5 (the time-limit flag) does not end the operation at once. It starts a short recheck: one more read in data-polling mode, two more in toggle mode. This separates an operation that finished late from one that really failed. Bus timing comes from three parameters: the address setup time before the strobe, the strobe width, and the hold time after the strobe, all counted in clocks.

Top module: `flash_pe_ctrl`

## Requirements
- R1: Opcode 0 (byte program) issues exactly four writes, as address/data: 555h/AAh, 2AAh/55h, 555h/A0h, then the target address with the request data byte.
- R2: Opcode 1 (sector erase) issues exactly six writes: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then the target (sector) address with 30h.
- R3: Opcode 2 (chip erase) issues exactly six writes: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h.
- R4: Every write holds `fl_we_no` low for exactly T_STROBE clocks, with `fl_ce_no` low, `fl_oe_no` high, and address and data unchanged during the low phase. Write and read strobes are never low together.
- R5: With `toggle_mode_i`=0, each status read goes to the target address. The operation completes with `done_o` when bit 7 of the read equals bit 7 of the expected data. The expected data is the request byte for a program and FFh for an erase.
- R6: With `toggle_mode_i`=0, a read whose bit 7 mismatches and whose bit 5 is 1 triggers exactly one further read. A match on that read gives `done_o`; a mismatch gives `fail_o`.
- R7: With `toggle_mode_i`=1, the operation completes with `done_o` when bit 6 is equal in two consecutive status reads.
- R8: With `toggle_mode_i`=1, a read where bit 6 has changed and bit 5 is 1 triggers exactly two further reads. If bit 6 is equal across those two reads the result is `done_o`; otherwise it is `fail_o`.
- R9: `start_i` is accepted only while `busy_o` is low and `op_i` is not 3. `busy_o` rises on the cycle after acceptance and stays high up to and including the cycle of the done or fail pulse. Starts while busy, and opcode 3, cause no bus activity.
- R10: `done_o` and `fail_o` are single-cycle pulses and never high together.
- R11: After reset `busy_o`, `done_o` and `fail_o` are low, and `fl_ce_no`, `fl_oe_no` and `fl_we_no` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| op_i | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| addr_i | input | AW | Program address or sector address |
| data_i | input | 8 | Byte to program |
| toggle_mode_i | input | 1 | 0 data polling on bit 7, 1 toggle detection on bit 6 |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Success pulse |
| fail_o | output | 1 | Failure pulse |
| fl_addr_o | output | AW | Flash address bus |
| fl_dq_o | output | 8 | Flash write data |
| fl_dq_i | input | 8 | Flash read data |
| fl_ce_no | output | 1 | Flash chip enable, active low |
| fl_oe_no | output | 1 | Flash output enable, active low |
| fl_we_no | output | 1 | Flash write enable, active low |

## Verification
Acceptance of a new request and the completion pulse can meet in one cycle: a start can arrive on the very edge at which `done_o` is high. The bench raises `start_i` exactly while the done pulse is visible and drops it one cycle later. It then expects `busy_o` to stay low and no further write to reach the flash. In a second case a start is pulsed in the middle of a program and must leave the write count at four. The status responder in the bench is scripted per vector: how many reads stay busy, and from which read bit 5 is set. This lets the late-success and true-failure paths of both polling modes be told apart by the exact number of status reads.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    V_AGAIN = 2'd0,
    V_OK    = 2'd1,
    V_FAIL  = 2'd2
  } verdict_e;

  typedef struct packed {
    logic        use_tgt;   // drive request address instead of fixed one
    logic        use_data;  // drive request byte instead of fixed one
    logic [11:0] addr;
    logic [7:0]  data;
  } cmd_t;

  function automatic cmd_t seq_word(op_e op, logic [2:0] step);
    cmd_t c;
    c = '{use_tgt: 1'b0, use_data: 1'b0, addr: 12'h555, data: 8'hAA};
    case (step)
      3'd0: ;
      3'd1, 3'd4: begin c.addr = 12'h2AA; c.data = 8'h55; end
      3'd2: c.data = (op == OP_PROG) ? 8'hA0 : 8'h80;
      3'd3: if (op == OP_PROG) begin c.use_tgt = 1'b1; c.use_data = 1'b1; end
      default: begin
        if (op == OP_SECT) begin c.use_tgt = 1'b1; c.data = 8'h30; end
        else c.data = 8'h10;
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle #(
  parameter int AW       = 20,
  parameter int T_SETUP  = 1,
  parameter int T_STROBE = 2,
  parameter int T_HOLD   = 1,
  parameter int CNT_W    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          ack_o,
  output logic [7:0]    rdata_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_dq_o,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_no,
  output logic          fl_oe_no,
  output logic          fl_we_no
);

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_HOLD} bst_e;

  localparam logic [CNT_W-1:0] LastSetup  = CNT_W'(T_SETUP - 1);
  localparam logic [CNT_W-1:0] LastStrobe = CNT_W'(T_STROBE - 1);
  localparam logic [CNT_W-1:0] LastHold   = CNT_W'(T_HOLD - 1);

  bst_e             st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic [AW-1:0]    addr_q;
  logic [7:0]       wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= B_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o <= 1'b0;
      case (st_q)
        B_IDLE: if (req_i) begin
          st_q    <= B_SETUP;
          cnt_q   <= '0;
          wr_q    <= wr_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
        end
        B_SETUP: if (cnt_q == LastSetup) begin
          st_q  <= B_STROBE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        B_STROBE: if (cnt_q == LastStrobe) begin
          if (!wr_q) rdata_o <= fl_dq_i;  // sample at end of read strobe
          st_q  <= B_HOLD;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: if (cnt_q == LastHold) begin
          st_q  <= B_IDLE;
          ack_o <= 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  assign fl_ce_no  = (st_q == B_IDLE);
  assign fl_we_no  = !((st_q == B_STROBE) && wr_q);
  assign fl_oe_no  = !((st_q == B_STROBE) && !wr_q);
  assign fl_addr_o = addr_q;
  assign fl_dq_o   = wdata_q;

  a_r4_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_we_no && !fl_oe_no));
  a_r4_strobe_in_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no || !fl_oe_no) |-> !fl_ce_no);
  a_r4_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no && $past(!fl_we_no)) |-> ($stable(fl_addr_o) && $stable(fl_dq_o)));

endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval
  import flash_pe_pkg::*;
(
  input  logic     tgl_i,
  input  logic     rd7_i,
  input  logic     rd6_i,
  input  logic     rd5_i,
  input  logic     exp7_i,
  input  logic     prev6_i,
  input  logic     have_prev_i,
  input  logic     recheck_i,
  output verdict_e verdict_o,
  output logic     have_prev_o,
  output logic     recheck_o
);

  always_comb begin
    verdict_o   = V_AGAIN;
    have_prev_o = have_prev_i;
    recheck_o   = recheck_i;
    if (!tgl_i) begin
      if (rd7_i == exp7_i)  verdict_o = V_OK;
      else if (recheck_i)   verdict_o = V_FAIL;
      else if (rd5_i)       recheck_o = 1'b1;
    end else begin
      if (!have_prev_i)           have_prev_o = 1'b1;
      else if (rd6_i == prev6_i)  verdict_o   = V_OK;
      else if (recheck_i)         verdict_o   = V_FAIL;
      else if (rd5_i) begin
        // restart with a fresh pair of reads
        recheck_o   = 1'b1;
        have_prev_o = 1'b0;
      end
    end
  end

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int AW       = 20,
  parameter int T_SETUP  = 1,
  parameter int T_STROBE = 2,
  parameter int T_HOLD   = 1,
  parameter int CNT_W    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          toggle_mode_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_dq_o,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_no,
  output logic          fl_oe_no,
  output logic          fl_we_no
);

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_POLL, ST_END} st_e;

  st_e           st_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          tgl_q, wait_q, fail_q, recheck_q, have_prev_q, prev6_q;
  logic [2:0]    step_q;

  logic          req, ack;
  logic [7:0]    rdata;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  cmd_t          cmd;
  verdict_e      verdict;
  logic          nxt_have_prev, nxt_recheck, exp7;
  logic [2:0]    last_step;

  assign cmd       = seq_word(op_q, step_q);
  assign last_step = (op_q == OP_PROG) ? 3'd3 : 3'd5;
  assign exp7      = (op_q == OP_PROG) ? data_q[7] : 1'b1;
  assign req       = ((st_q == ST_CMD) || (st_q == ST_POLL)) && !wait_q;
  assign bus_addr  = (st_q == ST_POLL || cmd.use_tgt) ? addr_q : AW'(cmd.addr);
  assign bus_wdata = cmd.use_data ? data_q : cmd.data;

  flash_bus_cycle #(
    .AW(AW), .T_SETUP(T_SETUP), .T_STROBE(T_STROBE), .T_HOLD(T_HOLD), .CNT_W(CNT_W)
  ) u_bus (
    .clk_i, .rst_ni,
    .req_i    (req),
    .wr_i     (st_q == ST_CMD),
    .addr_i   (bus_addr),
    .wdata_i  (bus_wdata),
    .ack_o    (ack),
    .rdata_o  (rdata),
    .fl_addr_o, .fl_dq_o, .fl_dq_i, .fl_ce_no, .fl_oe_no, .fl_we_no
  );

  flash_poll_eval u_eval (
    .tgl_i       (tgl_q),
    .rd7_i       (rdata[7]),
    .rd6_i       (rdata[6]),
    .rd5_i       (rdata[5]),
    .exp7_i      (exp7),
    .prev6_i     (prev6_q),
    .have_prev_i (have_prev_q),
    .recheck_i   (recheck_q),
    .verdict_o   (verdict),
    .have_prev_o (nxt_have_prev),
    .recheck_o   (nxt_recheck)
  );

  logic unused_rd;
  assign unused_rd = ^rdata[4:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      op_q        <= OP_PROG;
      addr_q      <= '0;
      data_q      <= '0;
      tgl_q       <= 1'b0;
      wait_q      <= 1'b0;
      fail_q      <= 1'b0;
      recheck_q   <= 1'b0;
      have_prev_q <= 1'b0;
      prev6_q     <= 1'b0;
      step_q      <= '0;
    end else begin
      if (req) wait_q <= 1'b1;
      case (st_q)
        ST_IDLE: if (start_i && op_i != 2'd3) begin
          st_q        <= ST_CMD;
          op_q        <= op_e'(op_i);
          addr_q      <= addr_i;
          data_q      <= data_i;
          tgl_q       <= toggle_mode_i;
          step_q      <= '0;
          recheck_q   <= 1'b0;
          have_prev_q <= 1'b0;
          fail_q      <= 1'b0;
          wait_q      <= 1'b0;
        end
        ST_CMD: if (ack) begin
          wait_q <= 1'b0;
          if (step_q == last_step) st_q <= ST_POLL;
          else step_q <= step_q + 1'b1;
        end
        ST_POLL: if (ack) begin
          wait_q      <= 1'b0;
          have_prev_q <= nxt_have_prev;
          recheck_q   <= nxt_recheck;
          prev6_q     <= rdata[6];
          if (verdict != V_AGAIN) begin
            st_q   <= ST_END;
            fail_q <= (verdict == V_FAIL);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_END) && !fail_q;
  assign fail_o = (st_q == ST_END) && fail_q;

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_fail_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);
  a_r9_busy_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o) |-> busy_o);
  a_r9_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i != 2'd3) |=> busy_o);
  a_r9_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i == 2'd3) |=> !busy_o);
  a_r4_no_write_in_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_POLL) |-> fl_we_no);

endmodule

// File: tb/flash_pe_ctrl_test.sv
module flash_pe_ctrl_test;

  localparam int AW = 20;
  localparam int TS = 2;
  localparam int TW = 3;
  localparam int TH = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    op = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = '0;
  logic          tgl = 1'b0;
  logic          busy, done, fail;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_o, fl_dq_i;
  logic          fl_ce_n, fl_oe_n, fl_we_n;

  always #5 clk = ~clk;

  flash_pe_ctrl #(.AW(AW), .T_SETUP(TS), .T_STROBE(TW), .T_HOLD(TH), .CNT_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
    .data_i(data), .toggle_mode_i(tgl), .busy_o(busy), .done_o(done), .fail_o(fail),
    .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_i(fl_dq_i),
    .fl_ce_no(fl_ce_n), .fl_oe_no(fl_oe_n), .fl_we_no(fl_we_n)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // flash model: bus monitor
  int            wr_n = 0, rd_n = 0, bad = 0, we_low = 0;
  bit            oe_low = 1'b0;
  logic [AW-1:0] la;
  logic [7:0]    ld;
  logic [AW+7:0] wlog [64];

  always @(negedge clk) begin
    if (!fl_we_n) begin
      if (we_low == 0) begin la = fl_addr; ld = fl_dq_o; end
      else if (fl_addr != la || fl_dq_o != ld) bad++;
      if (!fl_oe_n || fl_ce_n) bad++;
      we_low++;
    end else if (we_low != 0) begin
      wlog[wr_n % 64] = {la, ld};
      if (we_low != TW) bad++;
      wr_n++;
      we_low = 0;
    end
    if (!fl_oe_n) begin
      oe_low = 1'b1;
      if (fl_addr != addr) bad++;
    end else if (oe_low) begin
      rd_n++;
      oe_low = 1'b0;
    end
  end

  // status responder
  int       rd_base = 0, m_busy = 0, m_d5 = 0;
  logic [7:0] m_final = 8'hFF;
  int       ridx;
  logic [7:0] m_val;
  assign ridx = rd_n - rd_base;
  always_comb begin
    if (ridx < m_busy) m_val = {~m_final[7], ridx[0], (ridx >= m_d5), 5'b0};
    else               m_val = m_final;
  end
  assign fl_dq_i = (!fl_ce_n && !fl_oe_n) ? m_val : 8'h00;

  function automatic logic [AW+7:0] exp_wr(int o, int i, logic [AW-1:0] a, logic [7:0] d);
    logic [AW+7:0] e [6];
    e[0] = {AW'(12'h555), 8'hAA};
    e[1] = {AW'(12'h2AA), 8'h55};
    e[2] = {AW'(12'h555), (o == 0) ? 8'hA0 : 8'h80};
    e[3] = (o == 0) ? {a, d} : {AW'(12'h555), 8'hAA};
    e[4] = {AW'(12'h2AA), 8'h55};
    e[5] = (o == 1) ? {a, 8'h30} : {AW'(12'h555), 8'h10};
    return e[i];
  endfunction

  function automatic string wr_req(int o);
    case (o)
      0: return "R1";
      1: return "R2";
      default: return "R3";
    endcase
  endfunction

  function automatic string res_req(int m, int d5);
    if (m == 0) return (d5 < 50) ? "R6" : "R5";
    return (d5 < 50) ? "R8" : "R7";
  endfunction

  task automatic run_op(int o, int m, logic [AW-1:0] a, logic [7:0] d,
                        int nb, int d5, bit exp_fail, int exp_reads);
    int wbase, n, nw, badb;
    bit got_fail;
    m_busy  = nb;
    m_d5    = d5;
    m_final = (o == 0) ? d : 8'hFF;
    wbase   = wr_n;
    badb    = bad;
    @(negedge clk);
    rd_base = rd_n;
    start = 1'b1; op = 2'(o); addr = a; data = d; tgl = m[0];
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
    n = 0;
    while (!(done || fail) && n < 20000) begin @(negedge clk); n++; end
    got_fail = fail;
    chk(busy == 1'b1, "R9", "busy during end pulse", busy, 1);
    chk(got_fail == exp_fail, res_req(m, d5), "fail outcome", got_fail, exp_fail);
    chk(done == !exp_fail, res_req(m, d5), "done outcome", done, !exp_fail);
    @(negedge clk);
    chk(!done && !fail, "R10", "pulse width one cycle", {done, fail}, 0);
    chk(busy == 1'b0, "R9", "busy drops after pulse", busy, 0);
    nw = wr_n - wbase;
    chk(nw == ((o == 0) ? 4 : 6), wr_req(o), "write count", nw, (o == 0) ? 4 : 6);
    for (int i = 0; i < nw && i < 6; i++)
      chk(wlog[(wbase + i) % 64] == exp_wr(o, i, a, d), wr_req(o), "write word",
          wlog[(wbase + i) % 64], exp_wr(o, i, a, d));
    if (exp_reads != 0)
      chk(rd_n - rd_base == exp_reads, res_req(m, d5), "status read count",
          rd_n - rd_base, exp_reads);
    chk(bad == badb, "R4", "bus timing violations", bad - badb, 0);
  endtask

  // vectors: op, mode, addr, data, busy reads, first dq5 read, fail, reads
  localparam int         NV = 8;
  localparam int         V_OP  [NV] = '{0, 0, 1, 2, 0, 1, 0, 2};
  localparam int         V_MD  [NV] = '{0, 1, 0, 1, 0, 0, 1, 1};
  localparam logic [19:0] V_AD [NV] = '{20'h12345, 20'h0ABCD, 20'hF0000, 20'h00000,
                                        20'h00777, 20'h40000, 20'h00100, 20'h00000};
  localparam logic [7:0] V_DT  [NV] = '{8'h3C, 8'hC3, 8'h00, 8'h00, 8'h81, 8'h00, 8'h5A, 8'h00};
  localparam int         V_NB  [NV] = '{3, 3, 5, 4, 2, 100, 2, 100};
  localparam int         V_D5  [NV] = '{999, 999, 999, 999, 1, 1, 1, 1};
  localparam bit         V_FL  [NV] = '{0, 0, 0, 0, 0, 1, 0, 1};
  localparam int         V_RD  [NV] = '{4, 0, 6, 0, 3, 3, 4, 4};

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int wb;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !fail, "R11", "status after reset", {busy, done, fail}, 0);
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R11", "bus idle after reset",
        {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++)
      run_op(V_OP[v], V_MD[v], V_AD[v], V_DT[v], V_NB[v], V_D5[v], V_FL[v], V_RD[v]);

    // R9 reserved opcode ignored
    wb = wr_n;
    start = 1'b1; op = 2'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R9", "reserved opcode busy", busy, 0);
    chk(wr_n == wb, "R9", "reserved opcode writes", wr_n - wb, 0);

    // R9 start while busy ignored
    m_busy = 1; m_d5 = 999; m_final = 8'h11;
    wb = wr_n; rd_base = rd_n;
    start = 1'b1; op = 2'd0; addr = 20'h00042; data = 8'h11; tgl = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; op = 2'd2;
    @(negedge clk);
    start = 1'b0;
    while (!(done || fail)) @(negedge clk);
    // R9 start on the cycle of the done pulse is ignored
    start = 1'b1; op = 2'd2;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R9", "start at done pulse ignored", busy, 0);
    chk(wr_n - wb == 4, "R9", "writes with extra starts", wr_n - wb, 4);
    chk(wlog[(wb + 3) % 64] == {20'h00042, 8'h11}, "R1", "program word",
        wlog[(wb + 3) % 64], {20'h00042, 8'h11});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule